// File: doc/BRIEF.md
# UART Interrupt Source and Mask Logic

This block collects the status conditions of a small UART and turns them into four status bits and one active-low interrupt request. It takes the receive FIFO state (not empty, and the parity bit of the word at its head), framing events from the receiver, the transmit-buffer-empty level, the raw RX line and the power-mode and parity-enable settings. It reports data-available, transmit-empty, head-word parity and a shared activity/error bit. What the shared bit means depends on the power mode. In shutdown it reports whether the RX line has moved since shutdown began. In operating mode it reports a framing error.

Each source has its own mask bit. The data-available, parity and activity/error sources follow live state. The transmit-empty source is different: a latch catches the moment the buffer becomes empty, and it stays set until the strobe marking the end of a data-read transfer arrives. The interrupt output is registered, so it has no glitches.

Top module: `uart_irq_ctrl`

## Requirements
- R1: statR equals rxFifoNotEmpty at all times.
- R2: statPr is 1 only when parityEn is 1 and rxHeadParity is 1, and is 0 otherwise.
- R3: statT follows the live txEmpty level, including while or after the transmit latch is cleared.
- R4: statRaFe shows the RX-activity flag while shutdown is 1 and the framing-error flag while shutdown is 0.
- R5: The RX-activity flag is set by a change of the RX line, seen through a two-flop synchronizer, only while shutdown is 1. A change during operating mode leaves the flag at 0.
- R6: The RX-activity flag is cleared in the cycle after shutdown goes from 1 to 0.
- R7: The framing-error flag is set by frameErrEvt and cleared by frameOkEvt. If both arrive in the same cycle, the flag is set.
- R8: The transmit latch is set by a 0-to-1 change of txEmpty while maskT is 1, and cleared by readDoneStb. A set and a clear in the same cycle leave it set. txEmpty already at 1 when reset is released does not set it.
- R9: irqN is a register, active low. One cycle after the inputs, it is the inverse of the OR of (statR and maskR), (statPr and maskPr), (statRaFe and maskRaFe) and (transmit latch and maskT).
- R10: A source whose mask bit is 0 cannot pull irqN low.
- R11: A synchronous active-high reset clears the RX-activity, framing-error and transmit latches and drives irqN to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rxFifoNotEmpty | input | 1 | Receive FIFO holds unread data |
| rxHeadParity | input | 1 | Received parity bit of the oldest FIFO word |
| frameErrEvt | input | 1 | One-cycle pulse: stop bit sampled as 0 |
| frameOkEvt | input | 1 | One-cycle pulse: correctly framed character received |
| txEmpty | input | 1 | Transmit buffer empty level |
| rxLine | input | 1 | Raw asynchronous RX line |
| shutdown | input | 1 | 1 = shutdown mode, 0 = operating mode |
| parityEn | input | 1 | Parity enabled |
| maskR | input | 1 | Data-available interrupt enable |
| maskT | input | 1 | Transmit-empty interrupt enable |
| maskPr | input | 1 | Parity interrupt enable |
| maskRaFe | input | 1 | Activity/framing interrupt enable |
| readDoneStb | input | 1 | Chip-select rising edge ending a data-read transfer |
| statR | output | 1 | Data-available status |
| statT | output | 1 | Transmit-buffer-empty status |
| statPr | output | 1 | Head-word parity status |
| statRaFe | output | 1 | RX activity (shutdown) or framing error (operating) |
| irqN | output | 1 | Interrupt request, active low |

## Verification
The bench drives the RX line in operating mode, then enters shutdown and checks that the activity bit reads 0. A detector that ignored the mode would show stale activity here. It also leaves shutdown and enters it again, to confirm the activity bit was cleared; a missing clear would keep the interrupt pending. It fires set and clear in the same cycle on both the framing-error flag and the transmit latch. A design where the clear won would lose the event and leave irqN high. Finally, it reads statT after a read strobe has cleared the latch, and releases reset with txEmpty already at 1. A design that tied status to the latch, or that latched a level rather than an edge, would fail one of these two checks.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  typedef struct packed {
    logic raSet;   // RX moved while in shutdown
    logic raClr;   // shutdown just ended
    logic feSet;   // bad stop bit
    logic feClr;   // good frame
    logic txSet;   // transmit buffer just became empty, mask on
    logic txClr;   // read transfer finished
  } uirq_strobe_t;
endpackage

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
  import uirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rxLine,
  input  logic         shutdown,
  input  logic         txEmpty,
  input  logic         maskT,
  input  logic         frameErrEvt,
  input  logic         frameOkEvt,
  input  logic         readDoneStb,
  output uirq_strobe_t strb
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] rxSync;
  logic rxPrev;
  logic shutPrev;
  logic txPrev;
  logic rxEdge;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) rxSync[0] <= 1'b1;
        else     rxSync[0] <= rxLine;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) rxSync[g] <= 1'b1;
        else     rxSync[g] <= rxSync[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxPrev   <= 1'b1;
      shutPrev <= 1'b0;
      txPrev   <= 1'b1;   // no spurious latch if buffer already empty at reset release
    end else begin
      rxPrev   <= rxSync[LAST];
      shutPrev <= shutdown;
      txPrev   <= txEmpty;
    end
  end

  assign rxEdge = rxSync[LAST] ^ rxPrev;

  always_comb begin
    strb.raSet = shutdown & rxEdge;
    strb.raClr = shutPrev & ~shutdown;
    strb.feSet = frameErrEvt;
    strb.feClr = frameOkEvt;
    strb.txSet = txEmpty & ~txPrev & maskT;
    strb.txClr = readDoneStb;
  end

  // R8: a rising buffer-empty level with the mask on produces a set strobe
  a_r8_tx_edge_strobe: assert property (@(posedge clk) disable iff (rst)
    (txEmpty && !$past(txEmpty) && maskT && !$past(rst)) |-> strb.txSet);
endmodule

// File: rtl/uirq_dp.sv
module uirq_dp
  import uirq_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  uirq_strobe_t strb,
  input  logic         rxFifoNotEmpty,
  input  logic         rxHeadParity,
  input  logic         txEmpty,
  input  logic         shutdown,
  input  logic         parityEn,
  input  logic         maskR,
  input  logic         maskT,
  input  logic         maskPr,
  input  logic         maskRaFe,
  output logic         statR,
  output logic         statT,
  output logic         statPr,
  output logic         statRaFe,
  output logic         irqN
);
  logic raFlag;
  logic feFlag;
  logic txLatch;
  logic anySrc;

  // set has priority over clear in every latch
  always_ff @(posedge clk) begin
    if (rst) begin
      raFlag  <= 1'b0;
      feFlag  <= 1'b0;
      txLatch <= 1'b0;
    end else begin
      if (strb.raSet)      raFlag <= 1'b1;
      else if (strb.raClr) raFlag <= 1'b0;
      if (strb.feSet)      feFlag <= 1'b1;
      else if (strb.feClr) feFlag <= 1'b0;
      if (strb.txSet)      txLatch <= 1'b1;
      else if (strb.txClr) txLatch <= 1'b0;
    end
  end

  always_comb begin
    statR    = rxFifoNotEmpty;
    statT    = txEmpty;
    statPr   = parityEn & rxHeadParity;
    statRaFe = shutdown ? raFlag : feFlag;
    anySrc   = (statR & maskR) | (statPr & maskPr) |
               (statRaFe & maskRaFe) | (txLatch & maskT);
  end

  always_ff @(posedge clk) begin
    if (rst) irqN <= 1'b1;
    else     irqN <= ~anySrc;
  end

  a_r6_ra_cleared: assert property (@(posedge clk) disable iff (rst)
    strb.raClr |=> !raFlag);
  a_r5_ra_set: assert property (@(posedge clk) disable iff (rst)
    strb.raSet |=> raFlag);
  a_r7_fe_set_wins: assert property (@(posedge clk) disable iff (rst)
    strb.feSet |=> feFlag);
  a_r7_fe_clear: assert property (@(posedge clk) disable iff (rst)
    (strb.feClr && !strb.feSet) |=> !feFlag);
  a_r8_tx_clear: assert property (@(posedge clk) disable iff (rst)
    (strb.txClr && !strb.txSet) |=> !txLatch);
  a_r9_data_irq: assert property (@(posedge clk) disable iff (rst)
    (rxFifoNotEmpty && maskR) |=> !irqN);
  a_r10_all_masked: assert property (@(posedge clk) disable iff (rst)
    (!maskR && !maskT && !maskPr && !maskRaFe) |=> irqN);
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rxFifoNotEmpty,
  input  logic rxHeadParity,
  input  logic frameErrEvt,
  input  logic frameOkEvt,
  input  logic txEmpty,
  input  logic rxLine,
  input  logic shutdown,
  input  logic parityEn,
  input  logic maskR,
  input  logic maskT,
  input  logic maskPr,
  input  logic maskRaFe,
  input  logic readDoneStb,
  output logic statR,
  output logic statT,
  output logic statPr,
  output logic statRaFe,
  output logic irqN
);
  uirq_strobe_t strb;

  uirq_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rst(rst), .rxLine(rxLine), .shutdown(shutdown),
    .txEmpty(txEmpty), .maskT(maskT), .frameErrEvt(frameErrEvt),
    .frameOkEvt(frameOkEvt), .readDoneStb(readDoneStb), .strb(strb)
  );

  uirq_dp i_dp (
    .clk(clk), .rst(rst), .strb(strb),
    .rxFifoNotEmpty(rxFifoNotEmpty), .rxHeadParity(rxHeadParity),
    .txEmpty(txEmpty), .shutdown(shutdown), .parityEn(parityEn),
    .maskR(maskR), .maskT(maskT), .maskPr(maskPr), .maskRaFe(maskRaFe),
    .statR(statR), .statT(statT), .statPr(statPr), .statRaFe(statRaFe),
    .irqN(irqN)
  );
endmodule

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;
  logic clk = 1'b0;
  logic rst, rxFifoNotEmpty, rxHeadParity, frameErrEvt, frameOkEvt, txEmpty;
  logic rxLine, shutdown, parityEn, maskR, maskT, maskPr, maskRaFe, readDoneStb;
  logic statR, statT, statPr, statRaFe, irqN;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  uart_irq_ctrl i_uart_irq_ctrl (.*);

  // vector: {rxNe, hpar, pe, mR, mPr, expR, expPr, expIrqN}
  localparam logic [7:0] VEC [0:7] = '{
    8'b0_0_0_1_1_0_0_1,
    8'b1_0_0_1_0_1_0_0,
    8'b1_0_0_0_0_1_0_1,
    8'b0_1_1_0_1_0_1_0,
    8'b0_1_0_0_1_0_0_1,
    8'b0_1_1_0_0_0_1_1,
    8'b1_1_1_1_1_1_1_0,
    8'b0_0_1_1_1_0_0_1
  };

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    rst = 1; rxFifoNotEmpty = 0; rxHeadParity = 0; frameErrEvt = 0; frameOkEvt = 0;
    txEmpty = 1; rxLine = 1; shutdown = 0; parityEn = 0;
    maskR = 0; maskT = 1; maskPr = 0; maskRaFe = 0; readDoneStb = 0;
    cyc(3);
    chk(irqN, 1'b1, "R11 irqN in reset");
    chk(statRaFe, 1'b0, "R11 fe flag in reset");
    rst = 0;
    cyc(3);
    chk(irqN, 1'b1, "R8 no latch when empty at reset release");
    chk(statT, 1'b1, "R3 statT live");
    maskT = 0; txEmpty = 0;

    // R1 R2 R9 R10 table
    foreach (VEC[i]) begin
      {rxFifoNotEmpty, rxHeadParity, parityEn, maskR, maskPr} = VEC[i][7:3];
      cyc(2);
      chk(statR, VEC[i][2], $sformatf("R1 vec %0d", i));
      chk(statPr, VEC[i][1], $sformatf("R2 vec %0d", i));
      chk(irqN, VEC[i][0], $sformatf("R9/R10 vec %0d", i));
    end
    rxFifoNotEmpty = 0; maskR = 0; maskPr = 0; parityEn = 0;

    // R9 timing: one cycle after a source appears
    maskR = 1; rxFifoNotEmpty = 1;
    @(posedge clk); #1;
    chk(irqN, 1'b0, "R9 irqN one cycle after source");
    rxFifoNotEmpty = 0; maskR = 0;
    cyc(2);

    // R7 framing error
    maskRaFe = 1;
    frameErrEvt = 1; cyc(1); frameErrEvt = 0;
    cyc(1);
    chk(statRaFe, 1'b1, "R7 fe set");
    chk(irqN, 1'b0, "R7 fe irq");
    frameOkEvt = 1; cyc(1); frameOkEvt = 0;
    cyc(1);
    chk(statRaFe, 1'b0, "R7 fe cleared");
    chk(irqN, 1'b1, "R7 fe irq released");
    frameErrEvt = 1; frameOkEvt = 1; cyc(1); frameErrEvt = 0; frameOkEvt = 0;
    cyc(1);
    chk(statRaFe, 1'b1, "R7 set wins");
    maskRaFe = 0; cyc(2);
    chk(irqN, 1'b1, "R10 fe masked");
    // R4: shutdown shows activity flag (0) not the fe flag (1)
    shutdown = 1; cyc(1);
    chk(statRaFe, 1'b0, "R4 shutdown selects activity flag");
    shutdown = 0; cyc(1);
    chk(statRaFe, 1'b1, "R4 operating selects fe flag");
    frameOkEvt = 1; cyc(1); frameOkEvt = 0; cyc(1);

    // R5: RX motion in operating mode ignored
    rxLine = 0; cyc(5); rxLine = 1; cyc(5);
    shutdown = 1; cyc(2);
    chk(statRaFe, 1'b0, "R5 no activity from operating mode");
    // R5: motion during shutdown
    maskRaFe = 1;
    rxLine = 0; cyc(4);
    chk(statRaFe, 1'b1, "R5 activity set in shutdown");
    chk(irqN, 1'b0, "R5 activity irq");
    // R6: exit clears
    shutdown = 0; cyc(2);
    shutdown = 1; cyc(1);
    chk(statRaFe, 1'b0, "R6 activity cleared on exit");
    cyc(1);
    chk(irqN, 1'b1, "R6 irq released after exit");
    shutdown = 0; maskRaFe = 0; cyc(5);
    rxLine = 1; cyc(5);

    // R8 transmit latch
    maskT = 1; txEmpty = 1; cyc(2);
    chk(irqN, 1'b0, "R8 tx latch irq");
    readDoneStb = 1; cyc(1); readDoneStb = 0; cyc(1);
    chk(irqN, 1'b1, "R8 latch cleared by read strobe");
    chk(statT, 1'b1, "R3 statT polled after clear");
    // same-cycle set and clear
    txEmpty = 0; cyc(2);
    txEmpty = 1; readDoneStb = 1; cyc(1); readDoneStb = 0; cyc(1);
    chk(irqN, 1'b0, "R8 set wins over read strobe");
    readDoneStb = 1; cyc(1); readDoneStb = 0; cyc(1);
    // mask off at the edge: no latch
    maskT = 0; txEmpty = 0; cyc(2); txEmpty = 1; cyc(2);
    maskT = 1; cyc(2);
    chk(irqN, 1'b1, "R10 R8 edge with maskT=0 not latched");

    // R11 reset clears latched state
    txEmpty = 0; cyc(2); txEmpty = 1; cyc(2);
    rst = 1; cyc(2);
    chk(irqN, 1'b1, "R11 reset releases irq");
    rst = 0; cyc(3);
    chk(irqN, 1'b1, "R11 latch cleared by reset");
    summary();
  end
endmodule